// File: doc/BRIEF.md
# Atomic Operation Placement Predictor

This block picks, for every atomic memory operation that enters a core, the place where it should run: inside the local L1 data cache, or out at a shared outer cache level. It keeps a small direct-mapped table indexed by the low bits of the cache-block address. Each entry records the identity of the CPU that last touched the block and a saturating run counter of how many back-to-back touches that same CPU has made.

The route decision is combinational. It is taken in the request cycle from the entry as it stood before the request. The entry is then rewritten on the next rising clock edge. If the same CPU keeps hitting a block, that block eventually runs its atomics locally. As soon as another CPU touches the block, the run restarts and operations go outward again. Sending every operation outward is always correct, so local placement can be disabled entirely with a parameter.

Top module: `amo_locality_pred`

## Requirements
- R1: `route_local_o` is a combinational function of the request and the table state from before the request. The request that moves an entry over the limit is itself routed by the old count, and only the following access to that entry sees the new count.
- R2: With `req_valid_i` low, `route_local_o` is 0 (outer) and the table is left unchanged.
- R3: After reset every entry is invalid, and the first access to any entry is routed outer (0).
- R4: An access by a CPU other than the one recorded in a valid entry is routed outer. It overwrites the recorded CPU with its own ID and sets the run count to 1.
- R5: An access by the recorded CPU increments the run count. An access is routed local (1) only when the entry is valid, the CPU matches, and the stored count is strictly greater than `RUN_LIMIT`. With the defaults (limit 4), the sixth consecutive access by one CPU is the first local one.
- R6: The run count saturates at its all-ones value (7 by default) and does not wrap, so a long run stays local.
- R7: Entries for different block indices are tracked independently, even when their accesses are interleaved in time.
- R8: With `LOCAL_EN` = 0 every access is routed outer.
- R9: Idle cycles between accesses do not break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | An atomic operation is presented this cycle |
| req_block_i | input | IDX_W | Low cache-block address bits that select the table entry |
| req_cpu_i | input | CPU_W | ID of the requesting CPU |
| route_local_o | output | 1 | 1 = execute in the local L1, 0 = forward to the outer level |

## Verification
The checker verifies on every cycle that nothing is routed local without a request, that a back-to-back CPU change on the same block is always routed outer, that a local route by one CPU stays local on an immediate repeat, that the fallback build never routes local, and that the output is never unknown. Three behaviours can only be shown by the bench's scenarios: the exact access on which a run crosses the limit, the count restart at 1 after a CPU change, and the independence of interleaved entries. Two more also need the bench: entries surviving idle gaps, and every entry being cleared by reset.

// File: rtl/amo_pred_pkg.sv
package amo_pred_pkg;

    typedef enum logic {
        ROUTE_OUTER = 1'b0,
        ROUTE_LOCAL = 1'b1
    } route_e;

endpackage

// File: rtl/amo_pred_table.sv
module amo_pred_table #(
    parameter int IDX_W = 4,
    parameter int CPU_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_vld_o,
    output logic [CPU_W-1:0] rd_cpu_o,
    output logic [CNT_W-1:0] rd_cnt_o,
    input  logic             wr_en_i,
    input  logic [CPU_W-1:0] wr_cpu_i,
    input  logic [CNT_W-1:0] wr_cnt_i
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [CPU_W-1:0] cpu;
        logic [CNT_W-1:0] cnt;
    } entry_t;

    entry_t tbl_d [DEPTH];
    entry_t tbl_q [DEPTH];

    // Read side: the entry as it stood before this cycle's update.
    always_comb begin
        rd_vld_o = tbl_q[rd_idx_i].vld;
        rd_cpu_o = tbl_q[rd_idx_i].cpu;
        rd_cnt_o = tbl_q[rd_idx_i].cnt;
    end

    // Next-state: only the indexed entry changes, and only on a request.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_en_i) begin
            tbl_d[rd_idx_i].vld = 1'b1;
            tbl_d[rd_idx_i].cpu = wr_cpu_i;
            tbl_d[rd_idx_i].cnt = wr_cnt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

endmodule

// File: rtl/amo_pred_decide.sv
module amo_pred_decide
    import amo_pred_pkg::*;
#(
    parameter int CPU_W     = 3,
    parameter int CNT_W     = 3,
    parameter int RUN_LIMIT = 4,
    parameter bit LOCAL_EN  = 1'b1
) (
    input  logic             ent_vld_i,
    input  logic [CPU_W-1:0] ent_cpu_i,
    input  logic [CNT_W-1:0] ent_cnt_i,
    input  logic [CPU_W-1:0] req_cpu_i,
    output route_e           route_o,
    output logic [CPU_W-1:0] nxt_cpu_o,
    output logic [CNT_W-1:0] nxt_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W:0]   LIMIT   = (CNT_W+1)'(RUN_LIMIT);

    logic same_run;
    assign same_run = ent_vld_i && (ent_cpu_i == req_cpu_i);

    // Run-length update: extend and saturate, or restart at one.
    always_comb begin
        nxt_cpu_o = req_cpu_i;
        if (!same_run) begin
            nxt_cnt_o = CNT_ONE;
        end else if (ent_cnt_i == CNT_MAX) begin
            nxt_cnt_o = CNT_MAX;
        end else begin
            nxt_cnt_o = ent_cnt_i + CNT_ONE;
        end
    end

    generate
        if (LOCAL_EN) begin : g_predict
            always_comb begin
                if (same_run && ({1'b0, ent_cnt_i} > LIMIT)) begin
                    route_o = ROUTE_LOCAL;
                end else begin
                    route_o = ROUTE_OUTER;
                end
            end
        end else begin : g_fallback
            assign route_o = ROUTE_OUTER;
        end
    endgenerate

endmodule

// File: rtl/amo_locality_pred.sv
module amo_locality_pred
    import amo_pred_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int CPU_W     = 3,
    parameter int CNT_W     = 3,
    parameter int RUN_LIMIT = 4,
    parameter bit LOCAL_EN  = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [IDX_W-1:0] req_block_i,
    input  logic [CPU_W-1:0] req_cpu_i,
    output logic             route_local_o
);

    logic             ent_vld;
    logic [CPU_W-1:0] ent_cpu;
    logic [CNT_W-1:0] ent_cnt;
    logic [CPU_W-1:0] nxt_cpu;
    logic [CNT_W-1:0] nxt_cnt;
    route_e           route;

    amo_pred_table #(
        .IDX_W (IDX_W),
        .CPU_W (CPU_W),
        .CNT_W (CNT_W)
    ) u_table (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_idx_i (req_block_i),
        .rd_vld_o (ent_vld),
        .rd_cpu_o (ent_cpu),
        .rd_cnt_o (ent_cnt),
        .wr_en_i  (req_valid_i),
        .wr_cpu_i (nxt_cpu),
        .wr_cnt_i (nxt_cnt)
    );

    amo_pred_decide #(
        .CPU_W     (CPU_W),
        .CNT_W     (CNT_W),
        .RUN_LIMIT (RUN_LIMIT),
        .LOCAL_EN  (LOCAL_EN)
    ) u_decide (
        .ent_vld_i (ent_vld),
        .ent_cpu_i (ent_cpu),
        .ent_cnt_i (ent_cnt),
        .req_cpu_i (req_cpu_i),
        .route_o   (route),
        .nxt_cpu_o (nxt_cpu),
        .nxt_cnt_o (nxt_cnt)
    );

    assign route_local_o = req_valid_i && (route == ROUTE_LOCAL);

endmodule

// File: rtl/amo_pred_checker.sv
module amo_pred_checker #(
    parameter int IDX_W    = 4,
    parameter int CPU_W    = 3,
    parameter bit LOCAL_EN = 1'b1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_valid_i,
    input logic [IDX_W-1:0] req_block_i,
    input logic [CPU_W-1:0] req_cpu_i,
    input logic             route_local_o
);

    // R2: nothing goes local without a request
    p_idle_outer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |-> !route_local_o);

    // R1: decision is always a defined level
    p_known_route_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown(route_local_o));

    // R4: back-to-back CPU change on the same block goes outer
    p_cpu_change_outer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && $past(req_valid_i) && req_block_i == $past(req_block_i)
         && req_cpu_i != $past(req_cpu_i)) |-> !route_local_o);

    // R6: a local run repeated at once by the same CPU stays local (saturation)
    p_local_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && $past(req_valid_i && route_local_o)
         && req_block_i == $past(req_block_i) && req_cpu_i == $past(req_cpu_i))
        |-> route_local_o);

    generate
        if (!LOCAL_EN) begin : g_fb_chk
            // R8: fallback build never routes local
            p_fallback_outer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !route_local_o);
        end
    endgenerate

endmodule

bind amo_locality_pred amo_pred_checker #(
    .IDX_W    (IDX_W),
    .CPU_W    (CPU_W),
    .LOCAL_EN (LOCAL_EN)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_block_i   (req_block_i),
    .req_cpu_i     (req_cpu_i),
    .route_local_o (route_local_o)
);

// File: tb/test_amo_locality_pred.sv
module test_amo_locality_pred;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       req_valid_i = 1'b0;
    logic [3:0] req_block_i = '0;
    logic [2:0] req_cpu_i = '0;
    logic       route_local_o;
    logic       route_fb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk_i = ~clk_i;

    amo_locality_pred i_amo_locality_pred (
        .clk_i, .rst_ni, .req_valid_i, .req_block_i, .req_cpu_i, .route_local_o
    );

    amo_locality_pred #(.LOCAL_EN(1'b0)) i_amo_locality_pred_fb (
        .clk_i, .rst_ni, .req_valid_i, .req_block_i, .req_cpu_i,
        .route_local_o (route_fb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: route actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One access: drive after the falling edge, sample before the rising edge.
    task automatic access(input logic [3:0] blk, input logic [2:0] cpu,
                          input logic exp, input string req);
        @(negedge clk_i);
        req_valid_i = 1'b1;
        req_block_i = blk;
        req_cpu_i   = cpu;
        #2;
        check(req, route_local_o, exp);
        check("R8", route_fb, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            req_valid_i = 1'b0;
            req_block_i = 4'hF;
            req_cpu_i   = 3'd7;
            #2;
            check("R2", route_local_o, 1'b0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        req_valid_i = 1'b0;
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        #2;
        check("R2", route_local_o, 1'b0);
        access(4'd1, 3'd1, 1'b0, "R3");
        idle(1);
    endtask

    task automatic t_run_and_saturate();
        // R5: sixth consecutive access is the first local one
        for (int i = 1; i <= 6; i++) access(4'd2, 3'd1, (i == 6), "R5");
        // R6: stays local through saturation
        for (int i = 0; i < 6; i++) access(4'd2, 3'd1, 1'b1, "R6");
        idle(1);
    endtask

    task automatic t_cpu_switch();
        // R4: new CPU goes outer and restarts its run at one
        access(4'd2, 3'd3, 1'b0, "R4");
        for (int i = 2; i <= 6; i++) access(4'd2, 3'd3, (i == 6), "R4");
        // back to the old CPU: outer again
        access(4'd2, 3'd1, 1'b0, "R4");
        idle(1);
    endtask

    task automatic t_one_cycle_view();
        // R1: crossing request routed by old count, next one by new
        for (int i = 1; i <= 5; i++) access(4'd9, 3'd6, 1'b0, "R1");
        access(4'd9, 3'd6, 1'b1, "R1");
        idle(1);
    endtask

    task automatic t_interleave();
        // R7: two blocks trained in alternation do not disturb each other
        for (int i = 1; i <= 6; i++) begin
            access(4'd5, 3'd2, (i == 6), "R7");
            access(4'd6, 3'd4, (i == 6), "R7");
        end
    endtask

    task automatic t_idle_gap();
        // R9: run survives idle cycles
        idle(3);
        access(4'd5, 3'd2, 1'b1, "R9");
        idle(2);
        access(4'd6, 3'd4, 1'b1, "R9");
        idle(1);
    endtask

    task automatic t_reset_clears();
        do_reset();
        access(4'd5, 3'd2, 1'b0, "R3");
        access(4'd6, 3'd4, 1'b0, "R3");
        idle(1);
    endtask

    initial begin
        t_reset_state();
        t_run_and_saturate();
        t_cpu_switch();
        t_one_cycle_view();
        t_interleave();
        t_idle_gap();
        t_reset_clears();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule